// File: doc/BRIEF.md
# Timer Compare Channel Reference Generator

This block forms the reference waveform of one compare channel in a general-purpose timer. Each clock it takes the timer count, the channel's compare value, the count direction and a 4-bit mode selector, and computes the next level of a registered reference output. The available behaviours are:

- hold the level;
- set, clear or invert the level on an equal compare;
- force the level low or high;
- two PWM polarities;
- two retriggerable one-pulse polarities driven by a single-cycle trigger.

A second output carries a merged reference. In the combined and asymmetric modes it merges this channel's registered reference with the reference of a paired channel. In every other mode it follows this channel's own reference. The counter, preload shadowing, dead time and output polarity or enable stages sit outside the block.

Top module: `oc_mode_unit`

## Requirements
- R1: While rst_ni is low, ref_o is 0. After reset the pulse latch of R8 is cleared.
- R2: Mode 4'b0000 (hold) leaves ref_o at its current level whatever the counter does. The unused codes 4'b1010 and 4'b1011 behave the same way.
- R3: In mode 4'b0001, ref_o goes to 1 at an edge where cnt_i equals cmp_i. In mode 4'b0010, it goes to 0 at such an edge. With no equality, the level is held in both modes.
- R4: In mode 4'b0011, ref_o inverts at every edge where cnt_i equals cmp_i, and holds at other edges.
- R5: Mode 4'b0100 drives ref_o to 0 and mode 4'b0101 drives it to 1, whatever the counter value.
- R6: In mode 4'b0110 (PWM1) with dir_down_i=0, ref_o is 1 when cnt_i < cmp_i and 0 otherwise. With dir_down_i=1, ref_o is 0 when cnt_i > cmp_i and 1 otherwise.
- R7: Mode 4'b0111 (PWM2) yields the inverse of the R6 level for the same inputs.
- R8: In mode 4'b1000 (pulse1) with dir_down_i=0, ref_o is 1 until a trig_i pulse has been seen and 0 afterwards. The latch re-arms at an edge where cnt_i is 0 and trig_i is 0. With dir_down_i=1, ref_o is 0. Mode 4'b1001 (pulse2) gives the inverse. The latch records trig_i in every mode.
- R9: In mode 4'b1100, ref_o follows PWM1 and refc_o is ref_o OR peer_ref_i. In mode 4'b1101, ref_o follows PWM2 and refc_o is ref_o AND peer_ref_i. refc_o reacts to peer_ref_i without a clock.
- R10: In mode 4'b1110, ref_o follows PWM1; in mode 4'b1111, ref_o follows PWM2. In both, refc_o equals ref_o while dir_down_i=0 and equals peer_ref_i while dir_down_i=1.
- R11: In modes 4'b0000 through 4'b1011, refc_o equals ref_o.
- R12: ref_o is registered. Input changes reach it only at the next rising edge of clk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W | Timer count value |
| cmp_i | input | CNT_W | Channel compare value |
| dir_down_i | input | 1 | 1 while the timer counts down |
| trig_i | input | 1 | Single-cycle trigger pulse for the pulse modes |
| peer_ref_i | input | 1 | Reference of the paired channel |
| mode_i | input | 4 | Mode selector |
| ref_o | output | 1 | Registered channel reference |
| refc_o | output | 1 | Merged reference |

## Verification
The hardest state to reach is the re-arm of the pulse latch. It needs the latch set by a trigger first and then a cycle with the count at zero and no trigger present. The stimulus also has to avoid any zero count between the trigger and the check. The pulse task therefore opens with a zero count to clear any stale latch state. It then fires the trigger mid-period, steps through non-zero counts, and finally returns to zero to see the output come back. The asymmetric check is also subtle: the registered reference and the live direction must disagree. The stimulus does this by flipping dir_down_i and peer_ref_i between edges.

// File: rtl/oc_mode_pkg.sv
package oc_mode_pkg;
  typedef enum logic [3:0] {
    MODE_HOLD     = 4'b0000,
    MODE_SET      = 4'b0001,
    MODE_CLR      = 4'b0010,
    MODE_TOGGLE   = 4'b0011,
    MODE_FORCE_LO = 4'b0100,
    MODE_FORCE_HI = 4'b0101,
    MODE_PWM1     = 4'b0110,
    MODE_PWM2     = 4'b0111,
    MODE_PULSE1   = 4'b1000,
    MODE_PULSE2   = 4'b1001,
    MODE_COMB1    = 4'b1100,
    MODE_COMB2    = 4'b1101,
    MODE_ASYM1    = 4'b1110,
    MODE_ASYM2    = 4'b1111
  } oc_mode_e;
endpackage

// File: rtl/oc_cmp_eval.sv
module oc_cmp_eval #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             dir_down_i,
  output logic             match_o,
  output logic             pwm1_o
);
  always_comb begin
    match_o = (cnt_i == cmp_i);
    // up: high below compare; down: high at or below compare
    pwm1_o  = dir_down_i ? (cnt_i <= cmp_i) : (cnt_i < cmp_i);
  end
endmodule

// File: rtl/oc_trig_arm.sv
module oc_trig_arm #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             trig_i,
  output logic             fired_nx_o
);
  logic fired_q;
  logic cnt_zero;

  assign cnt_zero = (cnt_i == '0);

  always_comb begin
    if (trig_i)        fired_nx_o = 1'b1;
    else if (cnt_zero) fired_nx_o = 1'b0;
    else               fired_nx_o = fired_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fired_q <= 1'b0;
    else         fired_q <= fired_nx_o;
  end

  AST_TRIG_LATCHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> fired_q); // R8
  AST_ZERO_REARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_i && cnt_zero) |=> !fired_q); // R8
endmodule

// File: rtl/oc_ref_merge.sv
module oc_ref_merge
  import oc_mode_pkg::*;
(
  input  logic [3:0] mode_i,
  input  logic       dir_down_i,
  input  logic       ref_i,
  input  logic       peer_i,
  output logic       refc_o
);
  always_comb begin
    case (oc_mode_e'(mode_i))
      MODE_COMB1:             refc_o = ref_i | peer_i;
      MODE_COMB2:             refc_o = ref_i & peer_i;
      MODE_ASYM1, MODE_ASYM2: refc_o = dir_down_i ? peer_i : ref_i;
      default:                refc_o = ref_i;
    endcase
  end
endmodule

// File: rtl/oc_mode_unit.sv
module oc_mode_unit
  import oc_mode_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             dir_down_i,
  input  logic             trig_i,
  input  logic             peer_ref_i,
  input  logic [3:0]       mode_i,
  output logic             ref_o,
  output logic             refc_o
);
  logic match, pwm1, fired_nx;
  logic ref_q, ref_d;

  oc_cmp_eval #(.CNT_W(CNT_W)) u_cmp (
    .cnt_i     (cnt_i),
    .cmp_i     (cmp_i),
    .dir_down_i(dir_down_i),
    .match_o   (match),
    .pwm1_o    (pwm1)
  );

  oc_trig_arm #(.CNT_W(CNT_W)) u_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_i     (cnt_i),
    .trig_i    (trig_i),
    .fired_nx_o(fired_nx)
  );

  always_comb begin
    ref_d = ref_q;
    case (oc_mode_e'(mode_i))
      MODE_SET:      if (match) ref_d = 1'b1;
      MODE_CLR:      if (match) ref_d = 1'b0;
      MODE_TOGGLE:   if (match) ref_d = ~ref_q;
      MODE_FORCE_LO: ref_d = 1'b0;
      MODE_FORCE_HI: ref_d = 1'b1;
      MODE_PWM1, MODE_COMB1, MODE_ASYM1: ref_d = pwm1;
      MODE_PWM2, MODE_COMB2, MODE_ASYM2: ref_d = ~pwm1;
      MODE_PULSE1:   ref_d = dir_down_i ? 1'b0 : ~fired_nx;
      MODE_PULSE2:   ref_d = dir_down_i ? 1'b1 : fired_nx;
      default:       ref_d = ref_q; // hold and unused codes
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= ref_d;
  end

  assign ref_o = ref_q;

  oc_ref_merge u_merge (
    .mode_i    (mode_i),
    .dir_down_i(dir_down_i),
    .ref_i     (ref_q),
    .peer_i    (peer_ref_i),
    .refc_o    (refc_o)
  );

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b0000 || mode_i == 4'b1010 || mode_i == 4'b1011) |=> $stable(ref_q)); // R2
  AST_SET_ON_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b0001 && cnt_i == cmp_i) |=> ref_q); // R3
  AST_CLR_ON_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b0010 && cnt_i == cmp_i) |=> !ref_q); // R3
  AST_TOGGLE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b0011 && cnt_i == cmp_i) |=> (ref_q != $past(ref_q))); // R4
  AST_FORCE_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b0100) |=> !ref_q); // R5
  AST_FORCE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b0101) |=> ref_q); // R5
  AST_PWM1_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b0110 && !dir_down_i) |=> (ref_q == $past(cnt_i < cmp_i))); // R6
  AST_PULSE_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'b1000 && dir_down_i) |=> !ref_q); // R8
  AST_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[3:2] != 2'b11) |-> (refc_o == ref_o)); // R11
endmodule

// File: tb/oc_mode_unit_tb_top.sv
module oc_mode_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] cnt = '0, cmp = '0;
  logic dir_down = 1'b0, trig = 1'b0, peer = 1'b0;
  logic [3:0] mode = 4'b0000;
  logic ref_w, refc_w;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oc_mode_unit #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cmp_i(cmp),
    .dir_down_i(dir_down), .trig_i(trig), .peer_ref_i(peer),
    .mode_i(mode), .ref_o(ref_w), .refc_o(refc_w)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic [3:0] m, input int c, input logic d);
    mode = m; cnt = CNT_W'(c); dir_down = d;
  endtask

  task automatic t_reset();
    mode = 4'b0101; #1;
    chk("R1 reset low", ref_w, 1'b0);
    rst_n = 1'b1; step();
    chk("R5 force high", ref_w, 1'b1);
    chk("R11 mirror", refc_w, 1'b1);
    drive(4'b0100, 7, 1'b0); step();
    chk("R5 force low", ref_w, 1'b0);
    chk("R11 mirror low", refc_w, 1'b0);
  endtask

  task automatic t_match();
    cmp = 9;
    drive(4'b0001, 5, 1'b0); step(); chk("R3 set no eq", ref_w, 1'b0);
    drive(4'b0001, 9, 1'b0); step(); chk("R3 set on eq", ref_w, 1'b1);
    drive(4'b0001, 3, 1'b0); step(); chk("R3 set holds", ref_w, 1'b1);
    drive(4'b0010, 3, 1'b0); step(); chk("R3 clr no eq", ref_w, 1'b1);
    drive(4'b0010, 9, 1'b0); step(); chk("R3 clr on eq", ref_w, 1'b0);
    drive(4'b0011, 9, 1'b0); step(); chk("R4 toggle up", ref_w, 1'b1);
    step();                          chk("R4 toggle again", ref_w, 1'b0);
    drive(4'b0011, 4, 1'b0); step(); chk("R4 toggle holds", ref_w, 1'b0);
  endtask

  task automatic t_hold();
    drive(4'b0101, 0, 1'b0); step();
    drive(4'b0000, 9, 1'b0); step(); chk("R2 hold high on eq", ref_w, 1'b1);
    drive(4'b1010, 9, 1'b0); step(); chk("R2 code 1010 holds", ref_w, 1'b1);
    drive(4'b1011, 2, 1'b1); step(); chk("R2 code 1011 holds", ref_w, 1'b1);
    chk("R11 mirror in 1011", refc_w, 1'b1);
    drive(4'b0100, 0, 1'b0); step();
    drive(4'b0000, 2, 1'b0); step(); chk("R2 hold low", ref_w, 1'b0);
  endtask

  task automatic t_pwm();
    cmp = 10;
    drive(4'b0110, 9, 1'b0);  step(); chk("R6 up below", ref_w, 1'b1);
    drive(4'b0110, 10, 1'b0); #1;     chk("R12 no change before edge", ref_w, 1'b1);
    step();                           chk("R6 up equal", ref_w, 1'b0);
    drive(4'b0110, 11, 1'b1); step(); chk("R6 down above", ref_w, 1'b0);
    drive(4'b0110, 10, 1'b1); step(); chk("R6 down equal", ref_w, 1'b1);
    drive(4'b0110, 3, 1'b1);  step(); chk("R6 down below", ref_w, 1'b1);
    drive(4'b0111, 9, 1'b0);  step(); chk("R7 up below", ref_w, 1'b0);
    drive(4'b0111, 10, 1'b0); step(); chk("R7 up equal", ref_w, 1'b1);
    drive(4'b0111, 11, 1'b1); step(); chk("R7 down above", ref_w, 1'b1);
    drive(4'b0111, 10, 1'b1); step(); chk("R7 down equal", ref_w, 1'b0);
  endtask

  task automatic t_pulse();
    drive(4'b1000, 0, 1'b0); step(); chk("R8 armed at zero", ref_w, 1'b1);
    drive(4'b1000, 4, 1'b0); step(); chk("R8 still active", ref_w, 1'b1);
    trig = 1'b1; cnt = 5;    step(); chk("R8 trigger drops", ref_w, 1'b0);
    trig = 1'b0; cnt = 6;    step(); chk("R8 stays low", ref_w, 1'b0);
    cnt = 0;                 step(); chk("R8 re-armed", ref_w, 1'b1);
    drive(4'b1000, 7, 1'b1); step(); chk("R8 down inactive", ref_w, 1'b0);
    drive(4'b1001, 0, 1'b0); step(); chk("R8 pulse2 armed", ref_w, 1'b0);
    trig = 1'b1; cnt = 3;    step(); chk("R8 pulse2 trigger", ref_w, 1'b1);
    trig = 1'b0; drive(4'b1001, 3, 1'b1); step(); chk("R8 pulse2 down", ref_w, 1'b1);
  endtask

  task automatic t_merge();
    cmp = 10; peer = 1'b0;
    drive(4'b1100, 4, 1'b0); step(); chk("R9 comb1 ref", ref_w, 1'b1);
    chk("R9 or 1|0", refc_w, 1'b1);
    drive(4'b1100, 12, 1'b0); step(); chk("R9 or 0|0", refc_w, 1'b0);
    peer = 1'b1; #1; chk("R9 or 0|1", refc_w, 1'b1);
    drive(4'b1101, 12, 1'b0); step(); chk("R9 comb2 ref", ref_w, 1'b1);
    chk("R9 and 1&1", refc_w, 1'b1);
    peer = 1'b0; #1; chk("R9 and 1&0", refc_w, 1'b0);
    drive(4'b1110, 4, 1'b0); step(); chk("R10 up selects own", refc_w, 1'b1);
    dir_down = 1'b1; #1; chk("R10 down selects peer 0", refc_w, 1'b0);
    peer = 1'b1; #1;     chk("R10 down selects peer 1", refc_w, 1'b1);
    drive(4'b1111, 4, 1'b1); step(); chk("R10 asym2 ref", ref_w, 1'b0);
    dir_down = 1'b0; #1; chk("R10 asym2 up own", refc_w, 1'b0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    t_reset();
    t_match();
    t_hold();
    t_pwm();
    t_pulse();
    t_merge();
    finish_run();
  end
endmodule